// File: doc/BRIEF.md
# Configuration Packet Command Decoder

This block sits at the entry of a device's configuration logic. It takes a stream of 32-bit configuration words, one per cycle whenever `cfg_valid` is high, and never stalls the sender. A word seen in the header phase is decoded as a packet header. A write header sends the next N words to one register address. An all-zero word in the header phase is a pipeline flush and does nothing. A header with an unknown packet type raises a sticky framing-error flag.

Two addresses have a defined meaning. Address 9 holds the configuration-options word. Address 4 is the command register. Writing the start code (5) to the command register produces a one-cycle start-up request. Writing the CRC-reset code (7) produces a one-cycle CRC-reset pulse. Every other address lands in a general register array, which is read back through a combinational read port.

Top module: `cfg_packet_decoder`

## Requirements
- R1: After reset, the options register, the command register, every array entry, both pulses and the framing-error flag read 0, and `cfg_ready` reads 1.
- R2: Header 0x30012001 followed by one payload word stores that word in the options register (address 9). The new value is visible in the cycle after the payload is accepted.
- R3: Header 0x30008001 followed by one payload word stores that word in the command register (address 4).
- R4: Writing 0x00000005 to the command register drives `startup_pulse` high for exactly the one cycle after the payload is accepted.
- R5: Writing 0x00000007 to the command register drives `crc_reset_pulse` high for exactly the one cycle after the payload is accepted.
- R6: Writing any other value to the command register stores that value and produces neither pulse.
- R7: An all-zero word in the header phase changes no register and no flag, and the word after it is decoded as a header.
- R8: A nonzero header-phase word whose type field [31:29] is not 001 sets `frame_err`. That header is otherwise ignored, so the next word is decoded as a header. `frame_err` stays set until reset.
- R9: The header fields are: type [31:29], opcode [28:27] (10 = write), address [17:13] and count [10:0]. After a write header with count N > 0, exactly the next N accepted words are written to that address, in order, with the last one kept. Payload words are never decoded as headers. The word after the N-th payload word is decoded as a header.
- R10: A type-001 header whose opcode is not 10, or a write header with count 0, consumes no payload, so the next word is decoded as a header.
- R11: A write to an address other than 4 or 9 is stored in the general array, and `rd_data` shows the entry selected by `rd_addr` in the same cycle.
- R12: A cycle with `cfg_valid` low advances neither the header nor the payload state and changes no register or flag, whatever is on `cfg_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_valid | input | 1 | `cfg_word` carries a word this cycle |
| cfg_word | input | 32 | Configuration word |
| cfg_ready | output | 1 | Always high; the block accepts a word every cycle |
| rd_addr | input | 5 | Array read address |
| rd_data | output | 32 | Contents of the selected register |
| opt_reg | output | 32 | Configuration-options register (address 9) |
| cmd_reg | output | 32 | Command register (address 4) |
| startup_pulse | output | 1 | One-cycle start-up request |
| crc_reset_pulse | output | 1 | One-cycle CRC-reset request |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
A lost or extra count in the payload counter shows up within one word. A later header gets stored as data, so a register read back after the next write holds a header value. A payload word gets decoded as a header, which can raise `frame_err` when the payload has a bad type field. A wrong phase after a flush word, a no-op header or an idle cycle is caught the same way: the next header/payload pair lands in the wrong register or fires the wrong pulse. Pulse timing is checked in the exact cycle after the command payload is accepted and in the cycle after that.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 11;

  localparam logic [2:0] PTYPE_ONE = 3'b001;
  localparam logic [1:0] OP_WRITE  = 2'b10;

  typedef enum logic { PH_HDR, PH_DATA } phase_t;

  typedef struct packed {
    logic [2:0]       ptype;
    logic [1:0]       op;
    logic [8:0]       rsv_hi;
    logic [ADDR_W-1:0] addr;
    logic [1:0]       rsv_lo;
    logic [CNT_W-1:0] count;
  } hdr_t;
endpackage

// File: rtl/cfgdec_parser.sv
module cfgdec_parser
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              err_flag
);
  phase_t            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic              err_q, err_d;
  hdr_t              hdr;

  assign hdr = hdr_t'(in_word);

  always_comb begin
    phase_d  = phase_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    err_d    = err_q;
    wr_en    = 1'b0;
    if (in_valid) begin
      if (phase_q == PH_DATA) begin
        wr_en    = 1'b1;
        remain_d = remain_q - CNT_W'(1);
        if (remain_q == CNT_W'(1)) phase_d = PH_HDR;
      end else if (in_word == '0) begin
        phase_d = PH_HDR;
      end else if (hdr.ptype != PTYPE_ONE) begin
        err_d = 1'b1;
      end else if (hdr.op == OP_WRITE && hdr.count != '0) begin
        phase_d  = PH_DATA;
        addr_d   = hdr.addr;
        remain_d = hdr.count;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HDR;
      addr_q   <= '0;
      remain_q <= '0;
      err_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      err_q    <= err_d;
    end
  end

  assign wr_addr  = addr_q;
  assign wr_data  = in_word;
  assign err_flag = err_q;

  // R9
  data_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_DATA |-> remain_q != '0);
  // R12
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> in_valid);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7
  flush_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase_q == PH_HDR && in_word == '0) |=> ($stable(err_q) && phase_q == PH_HDR));
endmodule

// File: rtl/cfgdec_regfile.sv
module cfgdec_regfile
  import cfgdec_pkg::*;
#(
  parameter int OPT_ADDR = 9,
  parameter int CMD_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] opt_q,
  output logic [WORD_W-1:0] cmd_q
);
  localparam int NUM_REGS = 2 ** ADDR_W;

  logic [WORD_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic ld;
    assign ld = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (ld) begin
        regs_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = regs_q[rd_addr];
  assign opt_q   = regs_q[OPT_ADDR];
  assign cmd_q   = regs_q[CMD_ADDR];
endmodule

// File: rtl/cfgdec_cmdunit.sv
module cfgdec_cmdunit
  import cfgdec_pkg::*;
#(
  parameter int                CMD_ADDR   = 4,
  parameter logic [WORD_W-1:0] START_CODE = 32'h0000_0005,
  parameter logic [WORD_W-1:0] RCRC_CODE  = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              start_pls,
  output logic              rcrc_pls
);
  logic cmd_hit, start_d, rcrc_d, start_q, rcrc_q;

  always_comb begin
    cmd_hit = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
    start_d = cmd_hit && (wr_data == START_CODE);
    rcrc_d  = cmd_hit && (wr_data == RCRC_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      rcrc_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      rcrc_q  <= rcrc_d;
    end
  end

  assign start_pls = start_q;
  assign rcrc_pls  = rcrc_q;
endmodule

// File: rtl/cfg_packet_decoder.sv
module cfg_packet_decoder
  import cfgdec_pkg::*;
#(
  parameter int                OPT_ADDR   = 9,
  parameter int                CMD_ADDR   = 4,
  parameter logic [WORD_W-1:0] START_CODE = 32'h0000_0005,
  parameter logic [WORD_W-1:0] RCRC_CODE  = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [WORD_W-1:0] cfg_word,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] opt_reg,
  output logic [WORD_W-1:0] cmd_reg,
  output logic              startup_pulse,
  output logic              crc_reset_pulse,
  output logic              frame_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n   = rst_sync_q[1];
  assign cfg_ready = 1'b1;

  cfgdec_parser u_parser (
    .clk(clk), .rst_n(rst_i_n), .in_valid(cfg_valid), .in_word(cfg_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err_flag(frame_err)
  );

  cfgdec_regfile #(.OPT_ADDR(OPT_ADDR), .CMD_ADDR(CMD_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .opt_q(opt_reg), .cmd_q(cmd_reg)
  );

  cfgdec_cmdunit #(.CMD_ADDR(CMD_ADDR), .START_CODE(START_CODE), .RCRC_CODE(RCRC_CODE)) u_cmd (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start_pls(startup_pulse), .rcrc_pls(crc_reset_pulse)
  );

  // R4
  startup_matches_cmd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    startup_pulse |-> cmd_reg == START_CODE);
  // R5
  rcrc_matches_cmd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    crc_reset_pulse |-> cmd_reg == RCRC_CODE);
  // R6
  pulse_from_cmd_write_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (startup_pulse || crc_reset_pulse) |-> $past(wr_en && wr_addr == ADDR_W'(CMD_ADDR)));
endmodule

// File: tb/cfg_packet_decoder_test.sv
`timescale 1ns/1ps
module cfg_packet_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        cfg_ready;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data, opt_reg, cmd_reg;
  logic        startup_pulse, crc_reset_pulse, frame_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_packet_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .cfg_ready(cfg_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .opt_reg(opt_reg), .cmd_reg(cmd_reg), .startup_pulse(startup_pulse),
    .crc_reset_pulse(crc_reset_pulse), .frame_err(frame_err)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [31:0] opt;
    logic [31:0] cmd;
    logic        st;
    logic        crc;
    logic        err;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h3001_2001, 32'h0,         32'h0, 1'b0, 1'b0, 1'b0, "R9 "},
    '{32'h00A0_3FFF, 32'h00A0_3FFF, 32'h0, 1'b0, 1'b0, 1'b0, "R2 "},
    '{32'h3000_8001, 32'h00A0_3FFF, 32'h0, 1'b0, 1'b0, 1'b0, "R9 "},
    '{32'h0000_0005, 32'h00A0_3FFF, 32'h5, 1'b1, 1'b0, 1'b0, "R4 "},
    '{32'h3000_8001, 32'h00A0_3FFF, 32'h5, 1'b0, 1'b0, 1'b0, "R4 "},
    '{32'h0000_0007, 32'h00A0_3FFF, 32'h7, 1'b0, 1'b1, 1'b0, "R5 "},
    '{32'h0000_0000, 32'h00A0_3FFF, 32'h7, 1'b0, 1'b0, 1'b0, "R7 "},
    '{32'h3000_8001, 32'h00A0_3FFF, 32'h7, 1'b0, 1'b0, 1'b0, "R3 "},
    '{32'h0000_0003, 32'h00A0_3FFF, 32'h3, 1'b0, 1'b0, 1'b0, "R6 "},
    '{32'h0000_0000, 32'h00A0_3FFF, 32'h3, 1'b0, 1'b0, 1'b0, "R7 "}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cfg_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Called at a falling edge; returns at the next falling edge, after the word is taken.
  task automatic send(input logic [31:0] w);
    cfg_valid = 1'b1;
    cfg_word  = w;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic idle(input logic [31:0] junk);
    cfg_valid = 1'b0;
    cfg_word  = junk;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 opt", opt_reg, 32'h0);
    check("R1 cmd", cmd_reg, 32'h0);
    check("R1 pulses", {30'h0, startup_pulse, crc_reset_pulse}, 32'h0);
    check("R1 err", {31'h0, frame_err}, 32'h0);
    check("R1 ready", {31'h0, cfg_ready}, 32'h1);
    rd_addr = 5'd3;
    #1 check("R1 array", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].w);
      check({string'(VECS[i].tag), " opt"}, opt_reg, VECS[i].opt);
      check({string'(VECS[i].tag), " cmd"}, cmd_reg, VECS[i].cmd);
      check({string'(VECS[i].tag), " start"}, {31'h0, startup_pulse}, {31'h0, VECS[i].st});
      check({string'(VECS[i].tag), " crc"}, {31'h0, crc_reset_pulse}, {31'h0, VECS[i].crc});
      check({string'(VECS[i].tag), " err"}, {31'h0, frame_err}, {31'h0, VECS[i].err});
    end

    // R9 and R11: multi-word write to array address 3, payloads that look like headers
    do_reset();
    send(32'h3000_6003);
    send(32'hE000_0001);
    send(32'h0000_0000);
    rd_addr = 5'd3;
    #1 check("R9 mid-payload value", rd_data, 32'h0);
    send(32'h0000_0033);
    check("R9 payload not parsed as header", {31'h0, frame_err}, 32'h0);
    check("R11 array entry 3", rd_data, 32'h33);
    rd_addr = 5'd9;
    #1 check("R11 untouched entry", rd_data, 32'h0);
    send(32'h3000_8001);
    send(32'h0000_0007);
    check("R9 header after N words", {31'h0, crc_reset_pulse}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'h0, crc_reset_pulse}, 32'h0);

    // R10: no-op opcode, read opcode, zero-count write consume no payload
    send(32'h2001_2003);
    send(32'h3001_2001);
    send(32'hCAFE_F00D);
    check("R10 nop header", opt_reg, 32'hCAFE_F00D);
    send(32'h2801_2001);
    send(32'h3000_8001);
    send(32'h0000_0005);
    check("R10 other opcode", {31'h0, startup_pulse}, 32'h1);
    send(32'h3001_2000);
    send(32'h3000_8001);
    send(32'h0000_0009);
    check("R10 zero count", cmd_reg, 32'h9);
    check("R10 zero count opt kept", opt_reg, 32'hCAFE_F00D);

    // R12: idle cycles with junk on the bus
    idle(32'hE000_0000);
    idle(32'h3000_8001);
    check("R12 idle no err", {31'h0, frame_err}, 32'h0);
    send(32'h3000_8001);
    idle(32'h0000_0005);
    idle(32'h0000_0005);
    check("R12 idle no pulse", {31'h0, startup_pulse}, 32'h0);
    check("R12 idle cmd kept", cmd_reg, 32'h9);
    send(32'h0000_0005);
    check("R12 payload after idle", {31'h0, startup_pulse}, 32'h1);
    check("R4 cmd stored", cmd_reg, 32'h5);

    // R8: bad type sets sticky error, header ignored
    send(32'hE001_2001);
    check("R8 err set", {31'h0, frame_err}, 32'h1);
    send(32'h3001_2001);
    send(32'h1234_5678);
    check("R8 next word parsed as header", opt_reg, 32'h1234_5678);
    check("R8 err sticky", {31'h0, frame_err}, 32'h1);
    do_reset();
    check("R1 err cleared by reset", {31'h0, frame_err}, 32'h0);
    check("R1 opt cleared by reset", opt_reg, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule